// File: doc/BRIEF.md
# Parallel ADC Conversion-Read Sequencer

This block is a synchronous controller for a sampling analog-to-digital converter that has a 16-bit parallel result bus and that times its own conversions. User logic pulses `start_i`. The controller then pulls chip-select low and waits a setup interval. It drives convert-start low for a minimum width and watches the converter's busy flag through a two-flop synchronizer. After busy has been seen high and then low again, the controller lowers read and captures the result from the bus.

The result can be fetched in two ways. In word mode one read takes all 16 bits. In byte mode two reads take place over the upper eight bus lanes, with the byte-select pin picking which half appears there. The high half is read first and the low half second. The controller merges the two halves before it presents the word. The finished word appears on `result_o` together with a one-cycle `result_valid_o` strobe.

Every analog timing minimum is a parameter in nanoseconds. The block converts each one to whole clock cycles and rounds up. No read ever falls inside the protected window around the convert-start falling edge.

Top module: `adc_rdseq`

## Requirements
- R1: While reset is held and in the first cycle after it, chip-select, convert-start and read are high, byte-select is low, `result_valid_o` is low and `result_o` is zero.
- R2: An accepted start lowers chip-select one clock later. Chip-select stays low for SETUP cycles before convert-start falls, where SETUP = ceil(PRE_QUIET_NS / CLK_PERIOD_NS). It stays low until the last read is done.
- R3: Convert-start stays low for exactly ceil(CONV_LOW_NS / CLK_PERIOD_NS) cycles and then returns high.
- R4: Read falls only after the synchronized busy flag has been seen high and then low. When the quiet window has already expired, read falls on the third clock edge after busy drops.
- R5: Read is never low within QUIET = ceil(POST_QUIET_NS / CLK_PERIOD_NS) cycles of the convert-start falling edge. Its first low cycle is QUIET+1 cycles after the first low cycle of convert-start or later. At least SETUP high cycles of read come before any convert-start fall.
- R6: Read is low only while chip-select is low. Each read lasts READ_CYC cycles, and the bus is sampled at the clock edge that ends the read.
- R7: In word mode (`byte_mode_i` = 0) exactly one read takes place with byte-select low, and `result_o` takes the full 16-bit bus value.
- R8: In byte mode (`byte_mode_i` = 1) the first read has byte-select = 0, which puts result bits 15:8 on bus lanes 15:8. GAP_CYC cycles with read high and byte-select = 1 follow. The second read has byte-select = 1, which puts result bits 7:0 on lanes 15:8. `result_o` = {first byte, second byte}.
- R9: `result_valid_o` is high for exactly one cycle, the cycle after chip-select returns high. `result_o` keeps its value until the next capture.
- R10: A start request that arrives while a transaction is in progress is ignored. It produces no second convert-start fall and does not change the captured result.
- R11: `byte_mode_i` is sampled only in the cycle a start is accepted. Changing it later has no effect on the number of reads in that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request, taken only when idle |
| byte_mode_i | input | 1 | 1 selects the two-read byte transfer |
| adc_busy_i | input | 1 | Busy flag from the converter (asynchronous) |
| adc_data_i | input | 16 | Converter parallel data bus |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_convst_n_o | output | 1 | Converter convert-start, active low |
| adc_rd_n_o | output | 1 | Converter read enable, active low |
| adc_byte_o | output | 1 | Byte-select to the converter |
| result_o | output | 16 | Last captured two's complement word |
| result_valid_o | output | 1 | One-cycle strobe for a new `result_o` |

## Verification
All converter pins are registered, so a decision taken at a clock edge shows on the pins in the cycle that follows. Read therefore falls three edges after busy drops: two edges go through the synchronizer and one to the decision. When busy is very short, read falls instead QUIET+1 cycles after convert-start first reads low. The valid strobe comes one cycle after chip-select rises. The bench carries a behavioural model that advances on each rising edge, and it compares every pin and the result at the following falling edge, so each value is checked in the cycle it is due. Separate checks measure the busy-to-read and convert-to-read distances, the pulse widths and the read counts against these latencies for long busy, very short busy, both transfer modes and ignored start requests.

// File: rtl/adc_rdseq_pkg.sv
package adc_rdseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_WAIT,
    ST_READ_A,
    ST_GAP,
    ST_READ_B,
    ST_DONE
  } seq_state_t;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_rdseq_sync.sv
module adc_rdseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= 1'b0;
        else        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_rdseq_ctl.sv
module adc_rdseq_ctl
  import adc_rdseq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 5,
  parameter int unsigned CONV_CYC  = 2,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned READ_CYC  = 2,
  parameter int unsigned GAP_CYC   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic byte_mode_i,
  input  logic busy_s_i,
  output logic cs_n_o,
  output logic convst_n_o,
  output logic rd_n_o,
  output logic byte_o,
  output logic ld_word_o,
  output logic ld_hi_o,
  output logic ld_lo_o,
  output logic commit_o
);

  localparam int unsigned L01     = (SETUP_CYC > CONV_CYC) ? SETUP_CYC : CONV_CYC;
  localparam int unsigned L23     = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int unsigned L0123   = (L01 > L23) ? L01 : L23;
  localparam int unsigned LONGEST = (L0123 > GAP_CYC) ? L0123 : GAP_CYC;
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1) + 1;

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_MIN   = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] CNT_TOP    = {CNT_W{1'b1}};

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             mode_q, mode_en;
  logic             hold_met;
  logic             cs_n_d, convst_n_d, rd_n_d, byte_d;

  assign hold_met = (cnt_q >= HOLD_MIN);

  // Next-state process
  always_comb begin
    state_d   = state_q;
    cnt_d     = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
    seen_d    = seen_q;
    mode_en   = 1'b0;
    ld_word_o = 1'b0;
    ld_hi_o   = 1'b0;
    ld_lo_o   = 1'b0;
    commit_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i) begin
          state_d = ST_SETUP;
          mode_en = 1'b1;
          seen_d  = 1'b0;
        end
      end
      ST_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          state_d = ST_CONV;
          cnt_d   = '0;
        end
      end
      ST_CONV: begin
        if (busy_s_i) seen_d = 1'b1;
        if (cnt_q == CONV_LAST) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      ST_WAIT: begin
        if (busy_s_i) seen_d = 1'b1;
        if (hold_met && seen_q && !busy_s_i) begin
          state_d = ST_READ_A;
          cnt_d   = '0;
        end
      end
      ST_READ_A: begin
        if (cnt_q == READ_LAST) begin
          cnt_d = '0;
          if (mode_q) begin
            ld_hi_o = 1'b1;
            state_d = ST_GAP;
          end else begin
            ld_word_o = 1'b1;
            state_d   = ST_DONE;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = ST_READ_B;
          cnt_d   = '0;
        end
      end
      ST_READ_B: begin
        if (cnt_q == READ_LAST) begin
          ld_lo_o = 1'b1;
          state_d = ST_DONE;
          cnt_d   = '0;
        end
      end
      ST_DONE: begin
        commit_o = 1'b1;
        state_d  = ST_IDLE;
        cnt_d    = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // Pin values decoded from the next state, then registered so pins never glitch
  always_comb begin
    cs_n_d     = (state_d == ST_IDLE) || (state_d == ST_DONE);
    convst_n_d = (state_d != ST_CONV);
    rd_n_d     = !((state_d == ST_READ_A) || (state_d == ST_READ_B));
    byte_d     = (state_d == ST_GAP) || (state_d == ST_READ_B);
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      seen_q     <= 1'b0;
      cs_n_o     <= 1'b1;
      convst_n_o <= 1'b1;
      rd_n_o     <= 1'b1;
      byte_o     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      seen_q     <= seen_d;
      cs_n_o     <= cs_n_d;
      convst_n_o <= convst_n_d;
      rd_n_o     <= rd_n_d;
      byte_o     <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= byte_mode_i;
  end

endmodule

// File: rtl/adc_rdseq_pack.sv
module adc_rdseq_pack #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ld_word_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] hi_q, lo_q;
  logic              hi_en, lo_en;
  logic [HALF_W-1:0] hi_d, lo_d;

  // Byte mode always takes the upper lanes; word mode takes both halves at once
  always_comb begin
    hi_en = ld_word_i || ld_hi_i;
    lo_en = ld_word_i || ld_lo_i;
    hi_d  = data_i[DATA_W-1 -: HALF_W];
    lo_d  = ld_word_i ? data_i[HALF_W-1:0] : data_i[DATA_W-1 -: HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_o <= '0;
    else if (commit_i) result_o <= {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= commit_i;
  end

endmodule

// File: rtl/adc_rdseq.sv
module adc_rdseq
  import adc_rdseq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned CONV_LOW_NS   = 20,
  parameter int unsigned PRE_QUIET_NS  = 50,
  parameter int unsigned POST_QUIET_NS = 40,
  parameter int unsigned READ_CYC      = 2,
  parameter int unsigned GAP_CYC       = 1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_mode_i,
  input  logic              adc_busy_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_cs_n_o,
  output logic              adc_convst_n_o,
  output logic              adc_rd_n_o,
  output logic              adc_byte_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);

  localparam int unsigned SETUP_CYC = ns_to_cycles(PRE_QUIET_NS, CLK_PERIOD_NS);
  localparam int unsigned CONV_CYC  = ns_to_cycles(CONV_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned QUIET_CYC = ns_to_cycles(POST_QUIET_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC  = (QUIET_CYC > CONV_CYC) ? QUIET_CYC - CONV_CYC : 0;

  logic busy_s;
  logic ld_word, ld_hi, ld_lo, commit;

  adc_rdseq_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (adc_busy_i),
    .q_o   (busy_s)
  );

  adc_rdseq_ctl #(
    .SETUP_CYC (SETUP_CYC),
    .CONV_CYC  (CONV_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .READ_CYC  (READ_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_mode_i (byte_mode_i),
    .busy_s_i    (busy_s),
    .cs_n_o      (adc_cs_n_o),
    .convst_n_o  (adc_convst_n_o),
    .rd_n_o      (adc_rd_n_o),
    .byte_o      (adc_byte_o),
    .ld_word_o   (ld_word),
    .ld_hi_o     (ld_hi),
    .ld_lo_o     (ld_lo),
    .commit_o    (commit)
  );

  adc_rdseq_pack #(
    .DATA_W (DATA_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (adc_data_i),
    .ld_word_i (ld_word),
    .ld_hi_i   (ld_hi),
    .ld_lo_i   (ld_lo),
    .commit_i  (commit),
    .result_o  (result_o),
    .valid_o   (result_valid_o)
  );

endmodule

// File: rtl/adc_rdseq_chk.sv
module adc_rdseq_chk #(
  parameter int unsigned SETUP_CYC = 5,
  parameter int unsigned CONV_CYC  = 2,
  parameter int unsigned QUIET_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy_i,
  input logic cs_n,
  input logic convst_n,
  input logic rd_n,
  input logic valid
);

  localparam int unsigned AGE_TOP = 1000;

  int unsigned low_len;   // consecutive convst-low cycles so far
  int unsigned cv_age;    // cycles since convst was last low
  int unsigned rd_age;    // cycles since read was last low

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len <= 0;
      cv_age  <= AGE_TOP;
      rd_age  <= AGE_TOP;
    end else begin
      low_len <= convst_n ? 0 : low_len + 1;
      cv_age  <= !convst_n ? 0 : ((cv_age < AGE_TOP) ? cv_age + 1 : cv_age);
      rd_age  <= !rd_n ? 0 : ((rd_age < AGE_TOP) ? rd_age + 1 : rd_age);
    end
  end

  assert_cs_before_convst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> (!cs_n && !$past(cs_n)));

  assert_convst_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n) |-> (low_len >= CONV_CYC));

  assert_busy_low_before_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> !$past(busy_i, 3));

  assert_post_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && convst_n) |-> (cv_age + CONV_CYC >= QUIET_CYC));

  assert_no_read_in_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n |-> rd_n);

  assert_pre_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> (rd_age + 1 >= SETUP_CYC));

  assert_read_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

endmodule

bind adc_rdseq adc_rdseq_chk #(
  .SETUP_CYC (SETUP_CYC),
  .CONV_CYC  (CONV_CYC),
  .QUIET_CYC (QUIET_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_i   (adc_busy_i),
  .cs_n     (adc_cs_n_o),
  .convst_n (adc_convst_n_o),
  .rd_n     (adc_rd_n_o),
  .valid    (result_valid_o)
);

// File: tb/adc_rdseq_test.sv
module adc_rdseq_test;

  localparam int PER      = 10;
  localparam int PRE_NS   = 50;
  localparam int CONV_NS  = 20;
  localparam int QUIET_NS = 40;
  localparam int RDC      = 2;
  localparam int GAPC     = 1;
  localparam int P = (PRE_NS + PER - 1) / PER;
  localparam int C = (CONV_NS + PER - 1) / PER;
  localparam int Q = (QUIET_NS + PER - 1) / PER;
  localparam int R = (Q > C) ? Q - C : 0;

  logic        clk = 1'b0;
  logic        rst_n, start, byte_mode, busy;
  logic [15:0] adc_data, result;
  logic        cs_n, cv_n, rd_n, byte_sel, valid;

  always #5 clk = ~clk;

  adc_rdseq #(
    .CLK_PERIOD_NS (PER),
    .CONV_LOW_NS   (CONV_NS),
    .PRE_QUIET_NS  (PRE_NS),
    .POST_QUIET_NS (QUIET_NS),
    .READ_CYC      (RDC),
    .GAP_CYC       (GAPC),
    .SYNC_STAGES   (2),
    .DATA_W        (16)
  ) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .byte_mode_i    (byte_mode),
    .adc_busy_i     (busy),
    .adc_data_i     (adc_data),
    .adc_cs_n_o     (cs_n),
    .adc_convst_n_o (cv_n),
    .adc_rd_n_o     (rd_n),
    .adc_byte_o     (byte_sel),
    .result_o       (result),
    .result_valid_o (valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [15:0] adc_sample, adc_held;
  int  busy_len;
  int  bcnt;
  int  neg = 0;
  int  falls = 0, rd_falls = 0;
  int  fall_at = 0, first_rd_at = 0, last_rd_low_at = -100;
  int  cs_low_len = 0, cv_low_len = 0, rd_low_len = 0;
  bit  want_rd = 1'b0;
  logic prev_cv = 1'b1, prev_rd = 1'b1;

  // Bus is driven only while chip-select and read are both low
  assign adc_data = (!cs_n && !rd_n) ?
                    (byte_sel ? {adc_held[7:0], adc_held[15:8]} : adc_held) : 16'h0000;

  // ---------------- cycle reference model ----------------
  int   ph, n, mseen;
  logic mmode;
  logic [7:0]  hb, lb;
  logic        b1, b2;
  logic        m_cs, m_cv, m_rd, m_by, m_val;
  logic [15:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; n = 0; mseen = 0; mmode = 0; hb = 0; lb = 0; b1 = 0; b2 = 0;
      m_cs = 1; m_cv = 1; m_rd = 1; m_by = 0; m_val = 0; m_res = 0;
    end else begin
      logic bs;
      bs = b2;
      b2 = b1;
      b1 = busy;
      m_val = 0;
      case (ph)
        0: if (start) begin ph = 1; n = 0; mmode = byte_mode; mseen = 0; end
        1: if (n == P - 1) begin ph = 2; n = 0; end else n++;
        2: begin
             if (bs) mseen = 1;
             if (n == C - 1) begin ph = 3; n = 0; end else n++;
           end
        3: begin
             if (n >= R && mseen == 1 && !bs) begin ph = 4; n = 0; end
             else n++;
             if (bs) mseen = 1;
           end
        4: if (n == RDC - 1) begin
             hb = adc_data[15:8];
             n = 0;
             if (mmode) ph = 5;
             else begin lb = adc_data[7:0]; ph = 7; end
           end else n++;
        5: if (n == GAPC - 1) begin ph = 6; n = 0; end else n++;
        6: if (n == RDC - 1) begin lb = adc_data[15:8]; ph = 7; n = 0; end else n++;
        default: begin m_val = 1; m_res = {hb, lb}; ph = 0; end
      endcase
      m_cs = (ph == 0) || (ph == 7);
      m_cv = (ph != 2);
      m_rd = !((ph == 4) || (ph == 6));
      m_by = (ph == 5) || (ph == 6);
    end
  end

  // Compare and converter behaviour, away from the active edge
  always @(negedge clk) begin
    neg++;
    if (rst_n) begin
      check({cs_n, cv_n} == {m_cs, m_cv}, "R2", "cs/convst", {cs_n, cv_n}, {m_cs, m_cv});
      check({rd_n, byte_sel} == {m_rd, m_by}, "R6", "rd/byte", {rd_n, byte_sel}, {m_rd, m_by});
      check(valid == m_val, "R9", "valid", valid, m_val);
      check(result == m_res, "R7", "result", result, m_res);
      check(rd_n || !cs_n, "R6", "read without cs", rd_n, 1);
      if (!cv_n && prev_cv) begin
        check(!cs_n && cs_low_len + 1 >= P + 1, "R2", "cs low cycles before fall", cs_low_len + 1, P + 1);
        check(neg - last_rd_low_at - 1 >= P, "R5", "read-free cycles before fall", neg - last_rd_low_at - 1, P);
        if (!cs_n) begin
          falls++;
          fall_at = neg;
          want_rd = 1'b1;
          adc_held = adc_sample;
          busy = 1'b1;
          bcnt = busy_len;
        end
      end else if (bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) busy = 1'b0;
      end
      if (cv_n && !prev_cv)
        check(cv_low_len == C, "R3", "convst low width", cv_low_len, C);
      if (rd_n && !prev_rd)
        check(rd_low_len == RDC, "R6", "read low width", rd_low_len, RDC);
      if (!rd_n && prev_rd) begin
        rd_falls++;
        if (want_rd) begin first_rd_at = neg; want_rd = 1'b0; end
      end
      if (!rd_n) last_rd_low_at = neg;
      cs_low_len = cs_n ? 0 : cs_low_len + 1;
      cv_low_len = cv_n ? 0 : cv_low_len + 1;
      rd_low_len = rd_n ? 0 : rd_low_len + 1;
      prev_cv = cv_n;
      prev_rd = rd_n;
    end
  end

  task automatic conv(input bit mode, input logic [15:0] sample, input int blen, input bit extra);
    int f0, r0, exp_rd;
    adc_sample = sample;
    busy_len = blen;
    f0 = falls;
    r0 = rd_falls;
    byte_mode = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    byte_mode = ~mode;            // R11: later changes must not matter
    if (extra) begin
      repeat (P + C + 3) @(negedge clk);
      start = 1'b1;               // R10: request during a busy transaction
      @(negedge clk);
      start = 1'b0;
    end
    while (!valid) @(negedge clk);
    check(result == sample, mode ? "R8" : "R7", "captured word", result, sample);
    check(falls - f0 == 1, "R10", "convert-start falls", falls - f0, 1);
    check(rd_falls - r0 == (mode ? 2 : 1), "R11", "reads per transaction", rd_falls - r0, mode ? 2 : 1);
    exp_rd = (fall_at + blen + 3 > fall_at + Q + 1) ? fall_at + blen + 3 : fall_at + Q + 1;
    check(first_rd_at == exp_rd, (blen + 3 > Q + 1) ? "R4" : "R5",
          "first read cycle after convert", first_rd_at - fall_at, exp_rd - fall_at);
    @(negedge clk);
    check(!valid && result == sample, "R9", "strobe one cycle, result held", {valid, result}, {1'b0, sample});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; byte_mode = 1'b0; busy = 1'b0;
    adc_sample = 16'h0; adc_held = 16'h0; busy_len = 20; bcnt = 0;
    repeat (3) @(negedge clk);
    check({cs_n, cv_n, rd_n, byte_sel} == 4'b1110, "R1", "pins in reset", {cs_n, cv_n, rd_n, byte_sel}, 4'b1110);
    check(!valid && result == 16'h0, "R1", "outputs in reset", {valid, result}, 17'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cs_n, cv_n, rd_n, byte_sel} == 4'b1110, "R1", "pins after reset", {cs_n, cv_n, rd_n, byte_sel}, 4'b1110);
    conv(1'b0, 16'h8001, 20, 1'b0);
    conv(1'b1, 16'h7ffe, 20, 1'b0);
    conv(1'b0, 16'h1234, 1, 1'b0);
    conv(1'b1, 16'h00ff, 1, 1'b0);
    conv(1'b0, 16'hbeef, 20, 1'b1);
    conv(1'b1, 16'hff00, 5, 1'b1);
    conv(1'b1, 16'h5a3c, 2, 1'b0);
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=strobe");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule